// File: doc/BRIEF.md
# Reliable Message Sender Table

This block is the transmit end of a lightweight fault-tolerant messaging scheme for a network that may drop or reorder packets. A client hands it a message (destination node and a payload word). The block stamps the message with a fresh message ID and parks it in a small table. It then sends the message as a MSG packet, and keeps re-sending it until the receiver answers. The wait between sends grows by a fixed step each time.

The receiver answers with an ACK that carries the original ID and a short secondary ID of its own choosing. On an ACK that matches a live table entry, the block releases the entry and queues a CONF packet. The CONF packet carries only its type, the destination and the secondary ID. An ACK that matches nothing still produces a CONF, so the receiver can drop whatever state it holds for that exchange.

Message IDs come from a counter that never wraps. When the last ID has been issued, the block raises a network-flush request and refuses new messages until the flush is reported complete. The counter then restarts at zero.

Top module: `relmsg_sender`

## Requirements
- R1: After reset, no packet is offered (`pktValid` low), new messages and ACKs are accepted (`reqReady` and `ackReady` high), and `flushReq` is low.
- R2: An accepted message is offered as a MSG packet with `pktKind` = 2'b01. The packet carries the requested destination and payload, `pktSrc` equal to `myNode`, and `pktSid` of zero. IDs are issued in acceptance order, starting at 0 after reset and rising by one per message.
- R3: The table holds ENTRIES messages (8 by default). While every entry is live, `reqReady` is low.
- R4: A new message takes the lowest-numbered free entry. When several entries are due for transmission, the lowest-numbered entry is sent first.
- R5: A message that stays unacknowledged is re-sent. The output is assumed always ready, with nothing else pending. The gap between its k-th and (k+1)-th send is BACKOFF_BASE + BACKOFF_STEP*(k-1) cycles.
- R6: An ACK frees an entry only if `ackSrc` equals that entry's destination and `ackId` equals its ID. A freed message is never sent again. A mismatched ACK leaves the message live.
- R7: Every accepted ACK, matched or not, yields exactly one CONF packet with `pktKind` = 2'b10, `pktDest` = `ackSrc` and `pktSid` = `ackSid`. In that packet `pktSrc`, `pktId` and `pktData` are zero.
- R8: A waiting CONF is offered ahead of any MSG and holds steady until taken. While a CONF waits, `ackReady` is low.
- R9: Once ID 2^ID_W-1 has been issued, `flushReq` rises and `reqReady` stays low. A one-cycle `flushDone` pulse clears `flushReq`, and the next message receives ID 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| myNode | input | NODE_W | This node's number, placed in MSG packets |
| reqValid | input | 1 | New message offered |
| reqReady | output | 1 | New message can be accepted |
| reqDest | input | NODE_W | Destination node of the new message |
| reqData | input | DATA_W | Payload of the new message |
| ackValid | input | 1 | Incoming ACK offered |
| ackReady | output | 1 | ACK can be accepted |
| ackSrc | input | NODE_W | Node that sent the ACK |
| ackId | input | ID_W | Message ID being acknowledged |
| ackSid | input | SID_W | Receiver-chosen secondary ID |
| pktValid | output | 1 | Outgoing packet offered |
| pktReady | input | 1 | Network takes the outgoing packet |
| pktKind | output | 2 | 2'b01 MSG, 2'b10 CONF |
| pktDest | output | NODE_W | Packet destination |
| pktSrc | output | NODE_W | Source node (MSG only, else zero) |
| pktId | output | ID_W | Message ID (MSG only, else zero) |
| pktSid | output | SID_W | Secondary ID (CONF only, else zero) |
| pktData | output | DATA_W | Payload (MSG only, else zero) |
| flushReq | output | 1 | ID space exhausted, network flush needed |
| flushDone | input | 1 | Flush finished, restart IDs |

## Verification
Each kind of internal fault shows up at the ports, and most do so quickly:
- A corrupted backoff countdown or retry count moves the cycle stamp of the next resend. The bench measures each gap to the exact cycle, so the error appears within one backoff window.
- A wrong match, or a live bit that is not cleared, makes a supposedly retired ID reappear on the packet port. The bench watches for this over several windows.
- A wrong allocation or arbitration index shows up as an out-of-order ID in the very next packets.
- A stale ID counter shows up as the wrong ID on the first MSG after the fault, or as `flushReq` missing at the cycle after the last ID is issued.

// File: rtl/relmsg_pkg.sv
package relmsg_pkg;

  typedef enum logic [1:0] {
    PKT_NONE = 2'b00,
    PKT_MSG  = 2'b01,
    PKT_CONF = 2'b10
  } pkt_kind_e;

  // strobes from control to datapath, one handshake each
  typedef struct packed {
    logic allocEn;   // store the offered message
    logic sendMsg;   // MSG packet taken by the network
    logic sendConf;  // CONF packet taken by the network
    logic ackTake;   // ACK accepted this cycle
  } strobe_t;

endpackage

// File: rtl/relmsg_pick.sv
module relmsg_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  // lowest set bit wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/relmsg_ctrl.sv
module relmsg_ctrl
  import relmsg_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic [ENTRIES-1:0] liveVec,
  input  logic [ENTRIES-1:0] dueVec,
  input  logic               confPending,
  input  logic               exhausted,
  input  logic               reqValid,
  input  logic               ackValid,
  input  logic               pktReady,
  output logic               reqReady,
  output logic               ackReady,
  output logic               pktValid,
  output pkt_kind_e          pktKind,
  output strobe_t            strobe,
  output logic [IDX_W-1:0]   allocIdx,
  output logic [IDX_W-1:0]   sendIdx
);
  logic freeFound, dueFound;

  relmsg_pick #(.N(ENTRIES), .IW(IDX_W)) u_freePick (
    .vec(~liveVec), .found(freeFound), .idx(allocIdx)
  );

  relmsg_pick #(.N(ENTRIES), .IW(IDX_W)) u_duePick (
    .vec(dueVec & liveVec), .found(dueFound), .idx(sendIdx)
  );

  assign reqReady = freeFound && !exhausted;
  assign ackReady = !confPending;
  assign pktValid = confPending || dueFound;

  always_comb begin
    if (confPending)   pktKind = PKT_CONF;
    else if (dueFound) pktKind = PKT_MSG;
    else               pktKind = PKT_NONE;
  end

  always_comb begin
    strobe.allocEn  = reqValid && reqReady;
    strobe.ackTake  = ackValid && ackReady;
    strobe.sendConf = confPending && pktReady;
    strobe.sendMsg  = !confPending && dueFound && pktReady;
  end
endmodule

// File: rtl/relmsg_dp.sv
module relmsg_dp
  import relmsg_pkg::*;
#(
  parameter int ENTRIES      = 8,
  parameter int IDX_W        = 3,
  parameter int ID_W         = 48,
  parameter int NODE_W       = 10,
  parameter int SID_W        = 6,
  parameter int DATA_W       = 32,
  parameter int RETRY_W      = 4,
  parameter int CNT_W        = 16,
  parameter int BACKOFF_BASE = 16,
  parameter int BACKOFF_STEP = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  strobe_t             strobe,
  input  logic [IDX_W-1:0]    allocIdx,
  input  logic [IDX_W-1:0]    sendIdx,
  input  pkt_kind_e           pktKind,
  input  logic [NODE_W-1:0]   myNode,
  input  logic [NODE_W-1:0]   reqDest,
  input  logic [DATA_W-1:0]   reqData,
  input  logic [NODE_W-1:0]   ackSrc,
  input  logic [ID_W-1:0]     ackId,
  input  logic [SID_W-1:0]    ackSid,
  input  logic                flushDone,
  output logic [ENTRIES-1:0]  liveVec,
  output logic [ENTRIES-1:0]  dueVec,
  output logic                confPending,
  output logic                exhausted,
  output logic [NODE_W-1:0]   pktDest,
  output logic [NODE_W-1:0]   pktSrc,
  output logic [ID_W-1:0]     pktId,
  output logic [SID_W-1:0]    pktSid,
  output logic [DATA_W-1:0]   pktData
);
  logic [NODE_W-1:0] destArr [ENTRIES];
  logic [ID_W-1:0]   idArr   [ENTRIES];
  logic [DATA_W-1:0] dataArr [ENTRIES];
  logic [ENTRIES-1:0] matchVec;

  logic [ID_W-1:0]   idNext;
  logic [NODE_W-1:0] confDest;
  logic [SID_W-1:0]  confSid;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic              liveQ, dueQ;
    logic [NODE_W-1:0] destQ;
    logic [ID_W-1:0]   idQ;
    logic [DATA_W-1:0] dataQ;
    logic [RETRY_W-1:0] retryQ;
    logic [CNT_W-1:0]  cntQ;
    logic [CNT_W-1:0]  waitVal;
    logic allocHit, freeHit, sendHit;

    assign allocHit    = strobe.allocEn && (allocIdx == IDX_W'(i));
    assign matchVec[i] = liveQ && (destQ == ackSrc) && (idQ == ackId);
    assign freeHit     = strobe.ackTake && matchVec[i];
    assign sendHit     = strobe.sendMsg && (sendIdx == IDX_W'(i));
    // gap after this send, minus the cycle spent setting the due flag
    assign waitVal = CNT_W'(BACKOFF_BASE) + CNT_W'(BACKOFF_STEP) * CNT_W'(retryQ) - CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        liveQ  <= 1'b0;
        dueQ   <= 1'b0;
        destQ  <= '0;
        idQ    <= '0;
        dataQ  <= '0;
        retryQ <= '0;
        cntQ   <= '0;
      end else if (allocHit) begin
        liveQ  <= 1'b1;
        dueQ   <= 1'b1;
        destQ  <= reqDest;
        idQ    <= idNext;
        dataQ  <= reqData;
        retryQ <= '0;
        cntQ   <= '0;
      end else if (freeHit) begin
        liveQ <= 1'b0;
        dueQ  <= 1'b0;
      end else if (sendHit) begin
        dueQ <= 1'b0;
        cntQ <= waitVal;
        if (retryQ != '1) retryQ <= retryQ + 1'b1;
      end else if (liveQ && !dueQ) begin
        if (cntQ <= CNT_W'(1)) dueQ <= 1'b1;
        else                   cntQ <= cntQ - 1'b1;
      end
    end

    assign liveVec[i] = liveQ;
    assign dueVec[i]  = dueQ;
    assign destArr[i] = destQ;
    assign idArr[i]   = idQ;
    assign dataArr[i] = dataQ;
  end

  // ID counter: never wraps, waits for a network flush instead
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idNext    <= '0;
      exhausted <= 1'b0;
    end else if (exhausted) begin
      if (flushDone) begin
        exhausted <= 1'b0;
        idNext    <= '0;
      end
    end else if (strobe.allocEn) begin
      if (idNext == '1) exhausted <= 1'b1;
      else              idNext    <= idNext + 1'b1;
    end
  end

  // single CONF holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      confPending <= 1'b0;
      confDest    <= '0;
      confSid     <= '0;
    end else if (strobe.ackTake) begin
      confPending <= 1'b1;
      confDest    <= ackSrc;
      confSid     <= ackSid;
    end else if (strobe.sendConf) begin
      confPending <= 1'b0;
    end
  end

  always_comb begin
    pktDest = '0;
    pktSrc  = '0;
    pktId   = '0;
    pktSid  = '0;
    pktData = '0;
    case (pktKind)
      PKT_CONF: begin
        pktDest = confDest;
        pktSid  = confSid;
      end
      PKT_MSG: begin
        pktDest = destArr[sendIdx];
        pktSrc  = myNode;
        pktId   = idArr[sendIdx];
        pktData = dataArr[sendIdx];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/relmsg_sender.sv
module relmsg_sender
  import relmsg_pkg::*;
#(
  parameter int ENTRIES      = 8,
  parameter int ID_W         = 48,
  parameter int NODE_W       = 10,
  parameter int SID_W        = 6,
  parameter int DATA_W       = 32,
  parameter int RETRY_W      = 4,
  parameter int CNT_W        = 16,
  parameter int BACKOFF_BASE = 16,
  parameter int BACKOFF_STEP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NODE_W-1:0] myNode,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [NODE_W-1:0] reqDest,
  input  logic [DATA_W-1:0] reqData,
  input  logic              ackValid,
  output logic              ackReady,
  input  logic [NODE_W-1:0] ackSrc,
  input  logic [ID_W-1:0]   ackId,
  input  logic [SID_W-1:0]  ackSid,
  output logic              pktValid,
  input  logic              pktReady,
  output logic [1:0]        pktKind,
  output logic [NODE_W-1:0] pktDest,
  output logic [NODE_W-1:0] pktSrc,
  output logic [ID_W-1:0]   pktId,
  output logic [SID_W-1:0]  pktSid,
  output logic [DATA_W-1:0] pktData,
  output logic              flushReq,
  input  logic              flushDone
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  strobe_t            strobe;
  pkt_kind_e          kindInt;
  logic [ENTRIES-1:0] liveVec, dueVec;
  logic               confPending, exhausted;
  logic [IDX_W-1:0]   allocIdx, sendIdx;

  relmsg_ctrl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ctrl (
    .liveVec(liveVec), .dueVec(dueVec), .confPending(confPending),
    .exhausted(exhausted), .reqValid(reqValid), .ackValid(ackValid),
    .pktReady(pktReady), .reqReady(reqReady), .ackReady(ackReady),
    .pktValid(pktValid), .pktKind(kindInt), .strobe(strobe),
    .allocIdx(allocIdx), .sendIdx(sendIdx)
  );

  relmsg_dp #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .ID_W(ID_W), .NODE_W(NODE_W),
    .SID_W(SID_W), .DATA_W(DATA_W), .RETRY_W(RETRY_W), .CNT_W(CNT_W),
    .BACKOFF_BASE(BACKOFF_BASE), .BACKOFF_STEP(BACKOFF_STEP)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .allocIdx(allocIdx),
    .sendIdx(sendIdx), .pktKind(kindInt), .myNode(myNode),
    .reqDest(reqDest), .reqData(reqData), .ackSrc(ackSrc), .ackId(ackId),
    .ackSid(ackSid), .flushDone(flushDone), .liveVec(liveVec),
    .dueVec(dueVec), .confPending(confPending), .exhausted(exhausted),
    .pktDest(pktDest), .pktSrc(pktSrc), .pktId(pktId), .pktSid(pktSid),
    .pktData(pktData)
  );

  assign pktKind  = kindInt;
  assign flushReq = exhausted;
endmodule

// File: rtl/relmsg_sender_chk.sv
module relmsg_sender_chk #(
  parameter int ID_W   = 48,
  parameter int NODE_W = 10,
  parameter int SID_W  = 6,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NODE_W-1:0] myNode,
  input logic              reqValid,
  input logic              reqReady,
  input logic              ackValid,
  input logic              ackReady,
  input logic [NODE_W-1:0] ackSrc,
  input logic [SID_W-1:0]  ackSid,
  input logic              pktValid,
  input logic              pktReady,
  input logic [1:0]        pktKind,
  input logic [NODE_W-1:0] pktDest,
  input logic [NODE_W-1:0] pktSrc,
  input logic [ID_W-1:0]   pktId,
  input logic [SID_W-1:0]  pktSid,
  input logic [DATA_W-1:0] pktData,
  input logic              flushReq
);
  p_msg_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pktValid && pktKind == 2'b01 |-> pktSrc == myNode && pktSid == '0);

  p_kind_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pktValid |-> pktKind == 2'b01 || pktKind == 2'b10);

  p_conf_fields_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pktValid && pktKind == 2'b10 |-> pktSrc == '0 && pktId == '0 && pktData == '0);

  p_ack_to_conf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ackValid && ackReady |=> pktValid && pktKind == 2'b10
      && pktDest == $past(ackSrc) && pktSid == $past(ackSid));

  p_conf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pktValid && pktKind == 2'b10 && !pktReady |=>
      pktValid && pktKind == 2'b10 && $stable(pktDest) && $stable(pktSid));

  p_conf_blocks_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pktValid && pktKind == 2'b10 |-> !ackReady);

  p_flush_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flushReq |-> !reqReady);

  p_flush_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flushReq) |-> $past(reqValid && reqReady));
endmodule

bind relmsg_sender relmsg_sender_chk #(
  .ID_W(ID_W), .NODE_W(NODE_W), .SID_W(SID_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .myNode(myNode), .reqValid(reqValid),
  .reqReady(reqReady), .ackValid(ackValid), .ackReady(ackReady),
  .ackSrc(ackSrc), .ackSid(ackSid), .pktValid(pktValid),
  .pktReady(pktReady), .pktKind(pktKind), .pktDest(pktDest),
  .pktSrc(pktSrc), .pktId(pktId), .pktSid(pktSid), .pktData(pktData),
  .flushReq(flushReq)
);

// File: tb/sim_relmsg_sender.sv
module sim_relmsg_sender;
  localparam int NODE_W = 10;
  localparam int ID_W   = 4;
  localparam int SID_W  = 6;
  localparam int DATA_W = 32;
  localparam int BASE   = 4;
  localparam int STEP   = 3;
  localparam logic [1:0] K_MSG  = 2'b01;
  localparam logic [1:0] K_CONF = 2'b10;

  // unmatched-ACK vectors: stimulus {src, sid}, expected CONF dest/sid equal
  localparam int NVEC = 6;
  localparam int VSRC [NVEC] = '{3, 17, 255, 1023, 0, 64};
  localparam int VSID [NVEC] = '{1, 63, 0, 42, 7, 33};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NODE_W-1:0] myNode;
  logic reqValid, reqReady, ackValid, ackReady, pktValid, pktReady;
  logic flushReq, flushDone;
  logic [NODE_W-1:0] reqDest, ackSrc, pktDest, pktSrc;
  logic [DATA_W-1:0] reqData, pktData;
  logic [ID_W-1:0]   ackId, pktId;
  logic [SID_W-1:0]  ackSid, pktSid;
  logic [1:0]        pktKind;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nRun = 0;
  int nFail = 0;

  relmsg_sender #(
    .ID_W(ID_W), .NODE_W(NODE_W), .SID_W(SID_W), .DATA_W(DATA_W),
    .BACKOFF_BASE(BASE), .BACKOFF_STEP(STEP)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .myNode(myNode), .reqValid(reqValid),
    .reqReady(reqReady), .reqDest(reqDest), .reqData(reqData),
    .ackValid(ackValid), .ackReady(ackReady), .ackSrc(ackSrc), .ackId(ackId),
    .ackSid(ackSid), .pktValid(pktValid), .pktReady(pktReady),
    .pktKind(pktKind), .pktDest(pktDest), .pktSrc(pktSrc), .pktId(pktId),
    .pktSid(pktSid), .pktData(pktData), .flushReq(flushReq),
    .flushDone(flushDone)
  );

  logic [1:0]        gKind;
  logic [NODE_W-1:0] gDest, gSrc;
  logic [ID_W-1:0]   gId;
  logic [SID_W-1:0]  gSid;
  logic [DATA_W-1:0] gData;
  int gStamp;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic submit(input int dest, input int data);
    reqValid = 1'b1; reqDest = NODE_W'(dest); reqData = DATA_W'(data);
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic sendAck(input int src, input int id, input int sid);
    ackValid = 1'b1; ackSrc = NODE_W'(src); ackId = ID_W'(id); ackSid = SID_W'(sid);
    while (!ackReady) @(negedge clk);
    @(negedge clk);
    ackValid = 1'b0;
  endtask

  task automatic take(input bit keep);
    pktReady = 1'b1;
    while (!pktValid) @(negedge clk);
    gKind = pktKind; gDest = pktDest; gSrc = pktSrc; gId = pktId;
    gSid = pktSid; gData = pktData; gStamp = cyc;
    @(negedge clk);
    if (!keep) pktReady = 1'b0;
  endtask

  task automatic expectConf(input string tag, input int dest, input int sid);
    check(gKind == K_CONF, {tag, " kind"}, 64'(gKind), 64'(K_CONF));
    check(gDest == NODE_W'(dest), {tag, " dest"}, 64'(gDest), 64'(dest));
    check(gSid == SID_W'(sid), {tag, " sid"}, 64'(gSid), 64'(sid));
    check(gId == '0 && gData == '0 && gSrc == '0, {tag, " zero fields"},
          64'({gSrc, gId}), 64'(0));
  endtask

  task automatic expectMsg(input string tag, input int id);
    check(gKind == K_MSG, {tag, " kind"}, 64'(gKind), 64'(K_MSG));
    check(gId == ID_W'(id), {tag, " id"}, 64'(gId), 64'(id));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int t0;
    int seen;
    myNode = NODE_W'(77);
    reqValid = 0; reqDest = '0; reqData = '0;
    ackValid = 0; ackSrc = '0; ackId = '0; ackSid = '0;
    pktReady = 0; flushDone = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(!pktValid, "R1 pktValid", 64'(pktValid), 0);
    check(reqReady && ackReady, "R1 ready", 64'({reqReady, ackReady}), 64'(3));
    check(!flushReq, "R1 flushReq", 64'(flushReq), 0);

    // R7 vector table: unmatched ACKs still produce CONF
    for (int k = 0; k < NVEC; k++) begin
      sendAck(VSRC[k], 5, VSID[k]);
      take(1'b0);
      expectConf("R7 vec", VSRC[k], VSID[k]);
    end

    // R2 first message fields, R5 linear backoff
    submit(5, 32'hCAFE0001);
    take(1'b1);
    expectMsg("R2 first", 0);
    check(gDest == 10'd5 && gSrc == 10'd77, "R2 dest/src", 64'({gDest, gSrc}), 64'({10'd5, 10'd77}));
    check(gData == 32'hCAFE0001 && gSid == '0, "R2 data", 64'(gData), 64'h CAFE0001);
    t0 = gStamp;
    take(1'b1);
    expectMsg("R5 resend1", 0);
    check(gStamp - t0 == BASE, "R5 gap1", 64'(gStamp - t0), 64'(BASE));
    t0 = gStamp;
    take(1'b1);
    check(gStamp - t0 == BASE + STEP, "R5 gap2", 64'(gStamp - t0), 64'(BASE + STEP));
    t0 = gStamp;
    take(1'b0);
    check(gStamp - t0 == BASE + 2 * STEP, "R5 gap3", 64'(gStamp - t0), 64'(BASE + 2 * STEP));

    // R6 ACK from wrong node does not free the entry
    sendAck(6, 0, 11);
    take(1'b0);
    expectConf("R6 wrong src conf", 6, 11);
    take(1'b0);
    expectMsg("R6 still live", 0);
    sendAck(5, 0, 9);
    take(1'b1);
    expectConf("R6 match conf", 5, 9);
    seen = 0;
    repeat (40) begin
      @(negedge clk);
      if (pktValid) seen++;
    end
    pktReady = 1'b0;
    check(seen == 0, "R6 no resend after ACK", 64'(seen), 0);

    // R3 table full
    for (int k = 1; k <= 8; k++) submit(20 + k, k);
    check(!reqReady, "R3 full refuses", 64'(reqReady), 0);
    for (int k = 1; k <= 8; k++) begin
      sendAck(20 + k, k, k);
      take(1'b0);
      expectConf("R3 drain", 20 + k, k);
    end
    check(reqReady, "R3 free again", 64'(reqReady), 1);

    // R4 lowest free entry / lowest due first, R8 CONF priority
    submit(30, 9);   // entry 0, id 9
    submit(31, 10);  // entry 1, id 10
    submit(32, 11);  // entry 2, id 11
    sendAck(31, 10, 3);
    check(!ackReady, "R8 ackReady low while CONF waits", 64'(ackReady), 0);
    submit(33, 12);  // reuses entry 1
    take(1'b1);
    expectConf("R8 conf first", 31, 3);
    take(1'b1);
    expectMsg("R4 order a", 9);
    take(1'b1);
    expectMsg("R4 reused entry", 12);
    take(1'b0);
    expectMsg("R4 order c", 11);
    sendAck(30, 9, 1);  take(1'b0); expectConf("R4 retire", 30, 1);
    sendAck(33, 12, 2); take(1'b0); expectConf("R4 retire", 33, 2);
    sendAck(32, 11, 4); take(1'b0); expectConf("R4 retire", 32, 4);

    // R9 ID exhaustion and flush
    for (int id = 13; id <= 15; id++) begin
      submit(40, id);
      take(1'b0);
      expectMsg("R9 tail id", id);
      sendAck(40, id, 0);
      take(1'b0);
    end
    check(flushReq, "R9 flushReq", 64'(flushReq), 1);
    reqValid = 1'b1; reqDest = 10'd41; reqData = 32'h55;
    seen = 0;
    repeat (6) begin
      @(negedge clk);
      if (reqReady || pktValid) seen++;
    end
    reqValid = 1'b0;
    check(seen == 0, "R9 stalled", 64'(seen), 0);
    flushDone = 1'b1;
    @(negedge clk);
    flushDone = 1'b0;
    check(!flushReq, "R9 flush cleared", 64'(flushReq), 0);
    submit(41, 32'h77);
    take(1'b0);
    expectMsg("R9 restart id", 0);
    sendAck(41, 0, 5);
    take(1'b0);
    expectConf("R9 retire", 41, 5);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule